// File: doc/BRIEF.md
# Multichannel PDM-to-PCM FIR Decimator

This block turns the 1-bit pulse-density streams of several digital microphones into signed 16-bit PCM words. Each channel keeps its recent bits in a shift register. A long, symmetric, linear-phase low-pass FIR removes the shaped quantisation noise of the modulator. The filter is meant to pass 0 to 20 kHz, with its cutoff near 48 kHz and its stopband from 100 kHz. Because every input sample is only +1 or -1, each tap adds or subtracts its weight and needs no multiplier. Taps that mirror each other about the centre are merged, so each pair reduces to a three-way choice of +2w, 0 or -2w.

The microphone bit clock arrives as a clock enable, `pdm_en`, on the system clock. Every `DECIM` accepted bits, once the delay line holds a full window of history, the block evaluates all taps of all channels in parallel. It then presents one word per channel together with a single-cycle `pcm_valid` strobe. The channel count is a parameter, four by default and up to 32. The weights are computed inside the block from a fixed triangular rule, so the filter has no programmable state.

Top module: `pdm_fir_decim`

## Requirements
- R1: An active-high synchronous `rst` clears every history bit to 0, clears the accepted-bit and phase counters, and drives `pcm_valid` low and every PCM word to zero in the cycle after the reset edge.
- R2: A history bit of 1 contributes +w and a bit of 0 contributes -w, where w is the weight of its tap. A cleared history therefore reads as a full window of -1 samples.
- R3: The filter has NUM_TAPS = 98 taps. Tap t (0 is the newest accepted bit) has weight COEF_STEP*(min(t, 97-t)+1), with COEF_STEP = 24, so the weights are symmetric about the centre.
- R4: When `pdm_en` is low, `pdm_bits` is ignored: no history shifts and the bit count does not advance.
- R5: With n accepted bits since reset, a filter result is launched exactly when n is a multiple of DECIM (default 64). The strobe is high for one cycle per launch.
- R6: No result is launched while n < NUM_TAPS. With the defaults the first strobe follows bit 128.
- R7: The launching bit is sampled on clock edge E. `pcm_valid` and the new words are registered on edge E+1, and they reflect the history including that bit.
- R8: Each word is the channel's signed tap sum, shifted right arithmetically by OUT_SHIFT (default 0) and saturated to [-32768, 32767].
- R9: Between strobes the PCM words hold their last value.
- R10: Channels are filtered independently. Channel c uses `pdm_bits[c]` and drives `pcm_data[16c+15:16c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pdm_en | input | 1 | Accept one PDM bit per channel on this edge |
| pdm_bits | input | NUM_CH | One PDM bit per channel |
| pcm_valid | output | 1 | One-cycle strobe marking fresh PCM words |
| pcm_data | output | NUM_CH*16 | Packed signed PCM words, channel 0 in the low bits |

## Verification
A bit sampled on edge E is in the history after E, and when it completes a decimation period the strobe and the words appear after edge E+1. So a launching bit's result is due one full cycle after the next falling edge. The bench drives inputs and compares outputs on falling edges. It keeps a two-stage model: an accepted bit fills a pending slot, and that slot becomes the expected output one call later. Every cycle therefore compares the strobe and all words against the value due at that edge, which covers both launch timing and hold between strobes. The reset check is taken at the falling edge that follows the edges on which reset was sampled.

// File: rtl/pdm_fir_pkg.sv
package pdm_fir_pkg;

    // Weight of a mirrored tap pair; k counts from the outer ends inward.
    function automatic int pair_weight(input int step, input int k);
        return step * (k + 1);
    endfunction

    // Width of a counter that must reach 'limit' inclusive.
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit + 1) : 1;
    endfunction

endpackage

// File: rtl/pdm_history.sv
module pdm_history #(
    parameter int NUM_CH   = 4,
    parameter int NUM_TAPS = 98
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [NUM_CH-1:0]          bits_in,
    output logic [NUM_CH*NUM_TAPS-1:0] taps_out
);

    typedef struct packed {
        logic [NUM_TAPS-1:0] line;
    } line_t;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (shift_en) begin
                line_d.line = {line_q.line[NUM_TAPS-2:0], bits_in[c]};
            end
            if (rst) begin
                line_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            line_q <= line_d;
        end

        assign taps_out[c*NUM_TAPS +: NUM_TAPS] = line_q.line;

        // New bit lands at tap 0 on every accepted edge
        AST_NEWEST_AT_TAP0: assert property (@(posedge clk) disable iff (rst)
            shift_en |=> (line_q.line[0] == $past(bits_in[c]))); // R3
    end

endmodule

// File: rtl/pdm_decim_ctrl.sv
module pdm_decim_ctrl #(
    parameter int NUM_TAPS = 98,
    parameter int DECIM    = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    output logic fire,
    output logic filled
);

    localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int FILL_W = pdm_fir_pkg::cnt_width(NUM_TAPS);
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(DECIM - 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(NUM_TAPS);
    localparam logic [FILL_W-1:0] FILL_PRE = FILL_W'(NUM_TAPS - 1);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [FILL_W-1:0] fill;
        logic              fire;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (shift_en) begin
            if (st_q.fill != FILL_MAX) begin
                st_d.fill = st_q.fill + 1'b1;
            end
            if (st_q.phase == PH_LAST) begin
                st_d.phase = '0;
                st_d.fire  = (st_q.fill >= FILL_PRE);
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fire   = st_q.fire;
    assign filled = (st_q.fill == FILL_MAX);

    AST_NO_EARLY_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        st_q.fire |-> (st_q.fill == FILL_MAX)); // R6

    AST_LAUNCH_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        st_q.fire |-> $past(shift_en)); // R4

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.phase <= PH_LAST); // R5

endmodule

// File: rtl/pdm_fir_sum.sv
module pdm_fir_sum #(
    parameter int NUM_TAPS  = 98,
    parameter int COEF_STEP = 24,
    parameter int ACC_W     = 25,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 0
) (
    input  logic [NUM_TAPS-1:0]     taps,
    output logic signed [OUT_W-1:0] pcm
);

    localparam int NPAIR   = NUM_TAPS / 2;
    localparam int HAS_MID = NUM_TAPS % 2;
    localparam int MAX_I   = 2 ** (OUT_W - 1) - 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(MAX_I);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

    logic signed [ACC_W-1:0] pair_term [NPAIR];
    logic signed [ACC_W-1:0] mid_term;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    // Mirrored taps share one weight: both +1 -> +2w, both -1 -> -2w, else 0
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam logic signed [ACC_W-1:0] W2 =
            ACC_W'(2 * pdm_fir_pkg::pair_weight(COEF_STEP, k));
        logic lo_bit, hi_bit;
        assign lo_bit = taps[k];
        assign hi_bit = taps[NUM_TAPS-1-k];
        always_comb begin
            if (lo_bit && hi_bit) begin
                pair_term[k] = W2;
            end else if (lo_bit || hi_bit) begin
                pair_term[k] = '0;
            end else begin
                pair_term[k] = -W2;
            end
        end
    end

    if (HAS_MID != 0) begin : g_mid
        localparam logic signed [ACC_W-1:0] WM =
            ACC_W'(pdm_fir_pkg::pair_weight(COEF_STEP, NPAIR));
        assign mid_term = taps[NPAIR] ? WM : -WM;
    end else begin : g_nomid
        assign mid_term = '0;
    end

    always_comb begin
        acc = mid_term;
        for (int k = 0; k < NPAIR; k++) begin
            acc = acc + pair_term[k];
        end
        scaled = acc >>> OUT_SHIFT;
        if (scaled > SAT_HI) begin
            pcm = OUT_W'(SAT_HI);
        end else if (scaled < SAT_LO) begin
            pcm = OUT_W'(SAT_LO);
        end else begin
            pcm = OUT_W'(scaled);
        end
    end

endmodule

// File: rtl/pdm_fir_decim.sv
module pdm_fir_decim #(
    parameter int NUM_CH    = 4,
    parameter int NUM_TAPS  = 98,
    parameter int DECIM     = 64,
    parameter int COEF_W    = 16,
    parameter int COEF_STEP = 24,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pdm_en,
    input  logic [NUM_CH-1:0]       pdm_bits,
    output logic                    pcm_valid,
    output logic [NUM_CH*OUT_W-1:0] pcm_data
);

    localparam int ACC_W = COEF_W + $clog2(NUM_TAPS) + 2;

    typedef struct packed {
        logic                    valid;
        logic [NUM_CH*OUT_W-1:0] data;
    } out_t;

    logic [NUM_CH*NUM_TAPS-1:0] hist;
    logic [NUM_CH*OUT_W-1:0]    pcm_next;
    logic                       fire;
    logic                       filled;
    out_t                       out_d, out_q;

    pdm_history #(
        .NUM_CH   (NUM_CH),
        .NUM_TAPS (NUM_TAPS)
    ) u_history (
        .clk      (clk),
        .rst      (rst),
        .shift_en (pdm_en),
        .bits_in  (pdm_bits),
        .taps_out (hist)
    );

    pdm_decim_ctrl #(
        .NUM_TAPS (NUM_TAPS),
        .DECIM    (DECIM)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .shift_en (pdm_en),
        .fire     (fire),
        .filled   (filled)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sum
        pdm_fir_sum #(
            .NUM_TAPS  (NUM_TAPS),
            .COEF_STEP (COEF_STEP),
            .ACC_W     (ACC_W),
            .OUT_W     (OUT_W),
            .OUT_SHIFT (OUT_SHIFT)
        ) u_sum (
            .taps (hist[c*NUM_TAPS +: NUM_TAPS]),
            .pcm  (pcm_next[c*OUT_W +: OUT_W])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = fire;
        if (fire) begin
            out_d.data = pcm_next;
        end
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign pcm_valid = out_q.valid;
    assign pcm_data  = out_q.data;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!pcm_valid && (pcm_data == '0))); // R1

    AST_STROBE_FOLLOWS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        fire |=> pcm_valid); // R7

    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !pcm_valid); // R7

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pcm_data)); // R9

    AST_STROBE_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> filled); // R6

    if (DECIM > 1) begin : g_pulse_chk
        AST_SINGLE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
            pcm_valid |=> !pcm_valid); // R5
    end

endmodule

// File: tb/pdm_fir_decim_bench.sv
module pdm_fir_decim_bench;

    localparam int NCH   = 4;
    localparam int TAPS  = 98;
    localparam int D     = 64;
    localparam int STEP  = 24;
    localparam int SHIFT = 0;
    localparam int OW    = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pdm_en = 1'b0;
    logic [NCH-1:0]    pdm_bits = '0;
    logic              pcm_valid;
    logic [NCH*OW-1:0] pcm_data;

    int n_checks = 0;
    int n_fails  = 0;

    // bench-side model
    logic [TAPS-1:0] m_hist [NCH];
    int  nbits;
    bit  pend_fire;
    int  pend_data [NCH];
    bit  exp_valid;
    int  exp_data [NCH];
    int  lfsr = 32'h1ACE5;

    always #10 clk = ~clk; // 50 MHz

    pdm_fir_decim u_pdm_fir_decim (
        .clk       (clk),
        .rst       (rst),
        .pdm_en    (pdm_en),
        .pdm_bits  (pdm_bits),
        .pcm_valid (pcm_valid),
        .pcm_data  (pcm_data)
    );

    function automatic int ref_pcm(input logic [TAPS-1:0] h);
        int acc = 0;
        for (int t = 0; t < TAPS; t++) begin
            int m = (t < TAPS - 1 - t) ? t : TAPS - 1 - t;
            int w = STEP * (m + 1);
            acc += h[t] ? w : -w;
        end
        acc = acc >>> SHIFT;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    function automatic logic next_rand();
        lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
        return lfsr[7];
    endfunction

    task automatic check_int(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_outputs(input string req);
        check_int(req, "pcm_valid", int'(pcm_valid), int'(exp_valid));
        for (int c = 0; c < NCH; c++) begin
            logic signed [OW-1:0] w = pcm_data[c*OW +: OW];
            check_int(req, $sformatf("pcm ch%0d", c), int'(w), exp_data[c]);
        end
    endtask

    // One clock: compare what the previous edge produced, then drive new inputs
    task automatic cycle(input logic en, input logic [NCH-1:0] b, input string req);
        @(negedge clk);
        check_outputs(req);
        pdm_en   = en;
        pdm_bits = b;
        exp_valid = pend_fire;
        if (pend_fire) begin
            for (int c = 0; c < NCH; c++) exp_data[c] = pend_data[c];
        end
        pend_fire = 1'b0;
        if (en) begin
            nbits++;
            for (int c = 0; c < NCH; c++) m_hist[c] = {m_hist[c][TAPS-2:0], b[c]};
            if ((nbits % D) == 0 && nbits >= TAPS) begin
                pend_fire = 1'b1;
                for (int c = 0; c < NCH; c++) pend_data[c] = ref_pcm(m_hist[c]);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pdm_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            m_hist[c] = '0; exp_data[c] = 0; pend_data[c] = 0;
        end
        nbits = 0; pend_fire = 1'b0; exp_valid = 1'b0;
        check_outputs("R1");
        rst = 1'b0;
    endtask

    // R1: reset state at the ports
    task automatic t_reset_state();
        do_reset();
    endtask

    // R6, R8: all-ones saturates high; first strobe only after bit 128
    task automatic t_all_ones();
        for (int i = 0; i < 127; i++) cycle(1'b1, '1, "R6");
        cycle(1'b1, '1, "R6");
        cycle(1'b0, '0, "R7");
        cycle(1'b0, '0, "R7"); // strobe checked here
        check_int("R8", "ones saturate", int'($signed(pcm_data[OW-1:0])), 32767);
        for (int i = 0; i < 4; i++) cycle(1'b0, '0, "R9");
    endtask

    // R2, R8: all-zeros history reads as -1 everywhere and saturates low
    task automatic t_all_zeros();
        for (int i = 0; i < 2 * D + 2; i++) cycle(1'b1, '0, "R2");
        cycle(1'b0, '0, "R2");
        check_int("R8", "zeros saturate", int'($signed(pcm_data[OW-1:0])), -32768);
    endtask

    // R3, R10: distinct pattern per channel, continuous enable
    task automatic t_mixed();
        for (int i = 0; i < 5 * D; i++) begin
            logic [NCH-1:0] b;
            b[0] = i[0];
            b[1] = i[1];
            b[2] = next_rand();
            b[3] = (i % 5) < 3;
            cycle(1'b1, b, "R10");
        end
        repeat (3) cycle(1'b0, '0, "R3");
    endtask

    // R4, R5: gapped enable with noise on pdm_bits while disabled
    task automatic t_gaps();
        for (int i = 0; i < 900; i++) begin
            logic en = (i % 3) != 1;
            logic [NCH-1:0] b = {next_rand(), next_rand(), next_rand(), next_rand()};
            cycle(en, b, "R4");
        end
        repeat (3) cycle(1'b0, '1, "R5");
    endtask

    // R1, R6: reset in mid-stream restarts history and fill count
    task automatic t_mid_reset();
        for (int i = 0; i < 40; i++) cycle(1'b1, 4'b1010, "R1");
        do_reset();
        for (int i = 0; i < 100; i++) cycle(1'b1, 4'b0101, "R6");
        check_int("R6", "no strobe before bit 128 after reset", int'(pcm_valid), 0);
        for (int i = 0; i < 30; i++) cycle(1'b1, 4'b0110, "R6");
        repeat (2) cycle(1'b0, '0, "R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_all_ones();
        t_all_zeros();
        t_mixed();
        t_gaps();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule